// File: doc/BRIEF.md
# UART Interrupt Identification

This block turns the interrupt sources of a 16550-compatible serial port into a single identification code and one interrupt request line. Five sources compete: receiver line errors (overrun or break), character timeout, received data available, transmit holding register empty, and modem-status change. Each source is gated by its own enable bit. The highest-priority active source is reported, and the request line is high whenever any source is reported.

The code and the request line are purely combinational over the inputs and one internal state bit. That bit is the transmit-empty pending flag, which the block owns. When the surrounding port clears a line-error bit or a modem delta, the code follows in the same cycle with no extra re-evaluation step. The receive FIFO, the timeout counter and the modem-control logic sit outside and feed their conditions in. The reset input is asynchronous and active low, and it is expected to be released synchronously to the clock by the reset tree.

Top module: `uart_irq_ident`

## Requirements
- R1: The low nibble of `id_code` is 0x1 when no source is active, and `irq` is high exactly when the low nibble differs from 0x1.
- R2: Bits 7:6 of `id_code` are both 1 while `fifo_on` is high and both 0 otherwise. Bits 5:4 are always 0.
- R3: Among active sources the reported one follows this order, highest first: line status, character timeout, received data, transmit empty, modem status.
- R4: Line status (code 0x6) is active when `int_en[2]` is set and either bit of `line_err` (bit 0 overrun, bit 1 break) is set. Clearing those bits removes it in the same cycle.
- R5: Character timeout (code 0xC) is active when `int_en[0]` is set and `rx_timeout` is high.
- R6: With `fifo_on` low, received data (code 0x4) is active when `int_en[0]` is set and `rx_ready` is high, whatever `rx_count` and `rx_trig` hold.
- R7: With `fifo_on` high, received data additionally requires `rx_count` to be greater than or equal to `rx_trig`.
- R8: A `tx_empty_evt` pulse sets the pending flag, which is seen from the next cycle on. Transmit empty (code 0x2) is active when `int_en[1]` is set and the flag is set. The flag is kept while its enable is clear.
- R9: A `thr_wr` pulse clears the pending flag from the next cycle on. When `tx_empty_evt` is high in the same cycle, the flag ends up set.
- R10: An `id_rd` pulse clears the pending flag from the next cycle on, but only when the code shown during the read has low nibble 0x2. A read that shows any other code leaves the flag set.
- R11: Modem status (code 0x0) is active when `int_en[3]` is set and any bit of `modem_delta` is set.
- R12: After reset the pending flag is clear, so with all other inputs idle the code is 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 4 | Enables: bit 0 receive and timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status |
| fifo_on | input | 1 | FIFO mode enabled |
| rx_trig | input | CNT_W | Receive trigger level |
| rx_count | input | CNT_W | Characters held in the receive FIFO |
| rx_ready | input | 1 | Received data ready |
| rx_timeout | input | 1 | Character timeout condition |
| line_err | input | 2 | Pending line errors: bit 0 overrun, bit 1 break |
| modem_delta | input | N_DELTA | Modem status change bits |
| tx_empty_evt | input | 1 | One-cycle pulse: transmit holding register became empty |
| thr_wr | input | 1 | One-cycle pulse: host write to the transmit holding register |
| id_rd | input | 1 | One-cycle pulse: host read of the identification code |
| id_code | output | 8 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the trigger-level comparison at equality and one below. A design that ignores FIFO mode, or that uses a strict comparison, reports received data at the wrong fill. It reads the identification code while a higher source masks a pending transmit-empty. A design that clears the flag on every read then loses the transmit interrupt once that source goes away. It also hits a write and an empty event in the same cycle, where a clear-wins flag would drop a genuine empty event. It raises a pending flag while its enable is off and then enables it, to catch a design that discards the flag instead of masking it. Finally it stacks all five sources and removes them one by one, which exposes any swap in the priority chain.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 5;

  // Source slots, index 0 is the highest priority.
  localparam int SRC_LINE = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MDM  = 4;

  // Enable bit positions in int_en.
  localparam int EN_RXD  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam int ID_W = 4;

  localparam logic [ID_W-1:0] ID_NONE = 4'h1;
  localparam logic [ID_W-1:0] ID_LINE = 4'h6;
  localparam logic [ID_W-1:0] ID_RXD  = 4'h4;
  localparam logic [ID_W-1:0] ID_TMO  = 4'hC;
  localparam logic [ID_W-1:0] ID_THRE = 4'h2;
  localparam logic [ID_W-1:0] ID_MDM  = 4'h0;

  function automatic logic [ID_W-1:0] src_id(input int idx);
    logic [ID_W-1:0] r;
    case (idx)
      SRC_LINE: r = ID_LINE;
      SRC_TMO:  r = ID_TMO;
      SRC_RXD:  r = ID_RXD;
      SRC_THRE: r = ID_THRE;
      SRC_MDM:  r = ID_MDM;
      default:  r = ID_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/uart_irq_thre_flag.sv
module uart_irq_thre_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_clr,
  input  logic rd_clr,
  output logic pend
);

  logic pend_q;
  logic pend_d;
  logic pend_en;

  // Next state: a set event outranks either clear.
  always_comb begin
    pend_en = set_evt | wr_clr | rd_clr;
    pend_d  = pend_q;
    if (set_evt) begin
      pend_d = 1'b1;
    end else if (wr_clr || rd_clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R8 / R9: an empty event always leaves the flag set.
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);

  // R9: a holding-register write without an event clears the flag.
  p_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !set_evt) |=> !pend);

  // R8: with no event and no clear the flag holds its value.
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_evt || wr_clr || rd_clr) |=> $stable(pend));

endmodule

// File: rtl/uart_irq_qualify.sv
module uart_irq_qualify
  import uart_irq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int N_DELTA = 4
) (
  input  logic [3:0]         int_en,
  input  logic               fifo_on,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic               rx_ready,
  input  logic               rx_timeout,
  input  logic [1:0]         line_err,
  input  logic [N_DELTA-1:0] modem_delta,
  input  logic               thre_pend,
  output logic [NSRC-1:0]    req
);

  logic level_ok;
  logic rxd_gate;

  // In FIFO mode received data waits for the trigger level.
  always_comb begin
    level_ok = (rx_count >= rx_trig);
    rxd_gate = fifo_on ? level_ok : 1'b1;
  end

  always_comb begin
    req           = '0;
    req[SRC_LINE] = int_en[EN_LINE] & (|line_err);
    req[SRC_TMO]  = int_en[EN_RXD]  & rx_timeout;
    req[SRC_RXD]  = int_en[EN_RXD]  & rx_ready & rxd_gate;
    req[SRC_THRE] = int_en[EN_THRE] & thre_pend;
    req[SRC_MDM]  = int_en[EN_MDM]  & (|modem_delta);
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         none
);

  logic [N:0] taken;

  assign taken[0] = 1'b0;

  // Priority chain: slot i wins if it requests and nothing above it does.
  for (genvar i = 0; i < N; i++) begin : g_slot
    assign grant[i]    = req[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | req[i];
  end

  assign none = ~taken[N];

endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] grant,
  input  logic            none,
  output logic [ID_W-1:0] id_low
);

  logic [ID_W-1:0] id_acc;

  always_comb begin
    id_acc = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) begin
        id_acc = id_acc | src_id(i);
      end
    end
    id_low = none ? ID_NONE : id_acc;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int N_DELTA = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         int_en,
  input  logic               fifo_on,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic               rx_ready,
  input  logic               rx_timeout,
  input  logic [1:0]         line_err,
  input  logic [N_DELTA-1:0] modem_delta,
  input  logic               tx_empty_evt,
  input  logic               thr_wr,
  input  logic               id_rd,
  output logic [7:0]         id_code,
  output logic               irq
);

  localparam int CODE_W = 8;
  localparam int PAD_W  = CODE_W - ID_W - 2;

  logic            thre_pend;
  logic            rd_clr;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic            none;
  logic [ID_W-1:0] id_low;

  uart_irq_qualify #(
    .CNT_W   (CNT_W),
    .N_DELTA (N_DELTA)
  ) u_qualify (
    .int_en      (int_en),
    .fifo_on     (fifo_on),
    .rx_trig     (rx_trig),
    .rx_count    (rx_count),
    .rx_ready    (rx_ready),
    .rx_timeout  (rx_timeout),
    .line_err    (line_err),
    .modem_delta (modem_delta),
    .thre_pend   (thre_pend),
    .req         (req)
  );

  uart_irq_prio #(
    .N (NSRC)
  ) u_prio (
    .req   (req),
    .grant (grant),
    .none  (none)
  );

  uart_irq_encode u_encode (
    .grant  (grant),
    .none   (none),
    .id_low (id_low)
  );

  // A read clears the pending flag only when it is the source on show.
  assign rd_clr = id_rd & grant[SRC_THRE];

  uart_irq_thre_flag u_thre (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (tx_empty_evt),
    .wr_clr  (thr_wr),
    .rd_clr  (rd_clr),
    .pend    (thre_pend)
  );

  assign id_code = {{2{fifo_on}}, {PAD_W{1'b0}}, id_low};
  assign irq     = ~none;

  // R1: request line agrees with the reported code.
  p_irq_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_code[3:0] != ID_NONE));

  // R2: mode bits track FIFO enable, pad bits stay low.
  p_mode_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_code[7:6] == {2{fifo_on}}) && (id_code[5:4] == 2'b00));

  // R3 / R4: an enabled line error always wins.
  p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en[EN_LINE] && (|line_err)) |-> (id_code[3:0] == ID_LINE));

  // R7: below the trigger level in FIFO mode, received data is never shown.
  p_rxd_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && (rx_count < rx_trig)) |-> (id_code[3:0] != ID_RXD));

  // R10: reading while transmit empty is shown clears the flag.
  p_rd_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && (id_code[3:0] == ID_THRE) && !tx_empty_evt) |=> !thre_pend);

  // R10: reading while another code is shown keeps the flag.
  p_rd_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && thre_pend && (id_code[3:0] != ID_THRE) && !thr_wr) |=> thre_pend);

endmodule

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

  localparam int CNT_W   = 5;
  localparam int N_DELTA = 4;

  logic               clk;
  logic               rst_n;
  logic [3:0]         int_en;
  logic               fifo_on;
  logic [CNT_W-1:0]   rx_trig;
  logic [CNT_W-1:0]   rx_count;
  logic               rx_ready;
  logic               rx_timeout;
  logic [1:0]         line_err;
  logic [N_DELTA-1:0] modem_delta;
  logic               tx_empty_evt;
  logic               thr_wr;
  logic               id_rd;
  logic [7:0]         id_code;
  logic               irq;

  int checks;
  int fails;
  bit finished;

  uart_irq_ident #(.CNT_W(CNT_W), .N_DELTA(N_DELTA)) uut (
    .clk (clk), .rst_n (rst_n), .int_en (int_en), .fifo_on (fifo_on),
    .rx_trig (rx_trig), .rx_count (rx_count), .rx_ready (rx_ready),
    .rx_timeout (rx_timeout), .line_err (line_err), .modem_delta (modem_delta),
    .tx_empty_evt (tx_empty_evt), .thr_wr (thr_wr), .id_rd (id_rd),
    .id_code (id_code), .irq (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Compare code and request line; sampled 1 ns after a falling edge.
  task automatic expect_out(input string req, input string what, input logic [7:0] code);
    #1;
    check(req, {what, " code"}, id_code, code);
    check(req, {what, " irq"}, {7'd0, irq}, {7'd0, code[3:0] != 4'h1});
  endtask

  task automatic idle_inputs();
    int_en = 4'h0; fifo_on = 1'b0; rx_trig = '0; rx_count = '0;
    rx_ready = 1'b0; rx_timeout = 1'b0; line_err = 2'b00; modem_delta = '0;
    tx_empty_evt = 1'b0; thr_wr = 1'b0; id_rd = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_evt();
    tx_empty_evt = 1'b1;
    @(negedge clk);
    tx_empty_evt = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    expect_out("R12", "after reset", 8'h01);
    int_en = 4'hF;
    expect_out("R12", "enables on, flag clear", 8'h01);
  endtask

  task automatic t_fifo_bits();
    do_reset();
    fifo_on = 1'b1;
    expect_out("R2", "fifo on, idle", 8'hC1);
    int_en = 4'h8; modem_delta = 4'b0100;
    expect_out("R2", "fifo on, modem", 8'hC0);
    fifo_on = 1'b0;
    expect_out("R11", "modem delta", 8'h00);
    int_en = 4'h7;
    expect_out("R11", "modem enable off", 8'h01);
  endtask

  task automatic t_line();
    do_reset();
    int_en = 4'h4; line_err = 2'b01;
    expect_out("R4", "overrun", 8'h06);
    line_err = 2'b10;
    expect_out("R4", "break", 8'h06);
    line_err = 2'b00;
    expect_out("R4", "cleared same cycle", 8'h01);
    int_en = 4'h0; line_err = 2'b11;
    expect_out("R4", "line enable off", 8'h01);
  endtask

  task automatic t_rxd_no_fifo();
    do_reset();
    int_en = 4'h1; rx_ready = 1'b1; rx_trig = 5'd14; rx_count = 5'd0;
    expect_out("R6", "fifo off below level", 8'h04);
    rx_timeout = 1'b1;
    expect_out("R5", "timeout", 8'h0C);
    int_en = 4'h0;
    expect_out("R5", "timeout enable off", 8'h01);
  endtask

  task automatic t_rxd_fifo();
    do_reset();
    fifo_on = 1'b1; int_en = 4'h1; rx_ready = 1'b1; rx_trig = 5'd8;
    rx_count = 5'd7;
    expect_out("R7", "one below level", 8'hC1);
    rx_count = 5'd8;
    expect_out("R7", "at level", 8'hC4);
    rx_count = 5'd16;
    expect_out("R7", "above level", 8'hC4);
    rx_ready = 1'b0;
    expect_out("R7", "no data ready", 8'hC1);
  endtask

  task automatic t_thre_set();
    do_reset();
    int_en = 4'h2;
    tx_empty_evt = 1'b1;
    expect_out("R8", "event cycle", 8'h01);
    @(negedge clk);
    tx_empty_evt = 1'b0;
    expect_out("R8", "after event", 8'h02);
    // pending kept while masked
    do_reset();
    pulse_evt();
    expect_out("R8", "masked flag", 8'h01);
    int_en = 4'h2;
    expect_out("R8", "enabled later", 8'h02);
  endtask

  task automatic t_thr_write();
    do_reset();
    int_en = 4'h2;
    pulse_evt();
    thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
    expect_out("R9", "write clears", 8'h01);
    tx_empty_evt = 1'b1; thr_wr = 1'b1;
    @(negedge clk);
    tx_empty_evt = 1'b0; thr_wr = 1'b0;
    expect_out("R9", "event wins over write", 8'h02);
  endtask

  task automatic t_read_clear();
    do_reset();
    int_en = 4'h2;
    pulse_evt();
    id_rd = 1'b1;
    expect_out("R10", "code during read", 8'h02);
    @(negedge clk);
    id_rd = 1'b0;
    expect_out("R10", "read cleared", 8'h01);
    // read masked by a line error keeps the flag
    int_en = 4'h6;
    pulse_evt();
    line_err = 2'b01; id_rd = 1'b1;
    expect_out("R10", "masked read", 8'h06);
    @(negedge clk);
    id_rd = 1'b0; line_err = 2'b00;
    expect_out("R10", "flag survives masked read", 8'h02);
  endtask

  task automatic t_priority();
    do_reset();
    int_en = 4'hF;
    pulse_evt();
    line_err = 2'b01; rx_timeout = 1'b1; rx_ready = 1'b1; modem_delta = 4'b0001;
    expect_out("R3", "all active", 8'h06);
    line_err = 2'b00;
    expect_out("R3", "timeout next", 8'h0C);
    rx_timeout = 1'b0;
    expect_out("R3", "received data next", 8'h04);
    rx_ready = 1'b0;
    expect_out("R3", "transmit empty next", 8'h02);
    thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
    expect_out("R3", "modem last", 8'h00);
    modem_delta = '0;
    expect_out("R1", "nothing left", 8'h01);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_fifo_bits();
    t_line();
    t_rxd_no_fifo();
    t_rxd_fifo();
    t_thre_set();
    t_thr_write();
    t_read_clear();
    t_priority();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule